// File: doc/BRIEF.md
# Shared Cartridge Memory Ownership Arbiter

This block places one cartridge memory bus between a host CPU and a graphics coprocessor. Two control flags decide which side owns the bus: a coprocessor run flag and a memory-ownership flag. The host sets and clears both flags through a small byte-wide register port. The coprocessor owns the bus only when both flags are set. While it does, host reads never reach memory. Each host read instead returns one byte from a fixed 16-entry pattern, chosen by the low four address bits. The pattern is arranged so that interrupt vectors fetched from memory point at work-RAM locations.

While the host owns the bus, a coprocessor access request gets no grant, so the coprocessor waits until the host hands ownership back. The host side has no wait path at all. Ownership changes only on a host register write, and each write takes effect on the clock edge that accepts it.

Top module: `rom_share_arb`

## Requirements
- R1: After reset both flags are 0, so the host owns the bus: host reads are forwarded (`rom_rd` follows `host_rd`, `host_rdata` equals `rom_rdata`) and `cop_gnt` is 0.
- R2: The host's read is substituted only when the run flag and the ownership flag are both 1. In the other three flag combinations, `host_rdata` equals `rom_rdata`.
- R3: While substituting, `host_rdata` is the entry picked by `host_addr[3:0]`. Entries 0 to 15 in hex are: 00,01,00,01,04,01,00,01,00,01,08,01,00,01,0C,01. Upper data bits are zero when DW exceeds 8.
- R4: Address bits above bit 3 have no effect on the substitute byte.
- R5: While substituting, a host read does not drive `rom_rd`, and `rom_addr` carries `cop_addr`. While the host owns the bus, `rom_addr` carries `host_addr`.
- R6: While the host owns the bus, `cop_gnt` stays 0 even if `cop_req` is 1. While the coprocessor owns the bus, `cop_gnt` equals `cop_req` in the same cycle, and a granted request drives `rom_rd`.
- R7: A write with `cfg_we`=1 updates the selected flag at that clock edge. The new ownership is visible from the next cycle. With `cfg_we`=0 the flags do not change.
- R8: Register select 0 holds the run flag in data bit 5. Register select 1 holds the ownership flag in data bit 4. A write changes only the selected flag, and the other data bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_sel | input | 1 | Register select: 0 selects the run register, 1 the ownership register |
| cfg_wdata | input | 8 | Control write byte |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | AW (16) | Host address |
| host_rdata | output | DW (8) | Read data returned to the host |
| cop_req | input | 1 | Coprocessor access request |
| cop_addr | input | AW (16) | Coprocessor address |
| cop_gnt | output | 1 | Coprocessor grant; 0 means the coprocessor must stall |
| cop_rdata | output | DW (8) | Read data returned to the coprocessor |
| rom_rd | output | 1 | Read strobe to memory |
| rom_addr | output | AW (16) | Address to memory |
| rom_rdata | input | DW (8) | Data from memory |

## Verification
The bench drives all four flag combinations with distinct memory data on each. A design that decodes ownership with OR, or from only one of the flags, would then return the pattern where real data belongs, or the reverse.

All sixteen offsets are compared against the pattern, so a single wrong entry shows up. The offsets are also repeated with upper address bits set, which catches a decoder that uses more than four address bits.

Writes that carry unrelated data bits, or that target the other register, are checked for leaving the flags alone. So are stimuli with the write strobe low. A design that decodes the wrong bit would change ownership on these writes, and one that ignores the strobe would change it with the strobe low.

Coprocessor requests made while the host owns the bus must see no grant and no memory strobe, so a gate that leaks the request through is caught.

// File: rtl/rom_share_pkg.sv
package rom_share_pkg;

   localparam int unsigned NUM_FLAGS = 2;
   localparam int unsigned PAT_DEPTH = 16;
   localparam int unsigned PAT_IDX_W = $clog2(PAT_DEPTH);

   typedef enum logic [0:0] {
      FLG_RUN = 1'b0,
      FLG_OWN = 1'b1
   } flag_sel_e;

   // Substitute byte for one low-address offset.
   // Odd offsets return 01. Even offsets return zero, except the three that
   // redirect vectors into work RAM.
   function automatic logic [7:0] sub_byte(input logic [PAT_IDX_W-1:0] idx);
      logic [7:0] b;
      if (idx[0]) begin
         b = 8'h01;
      end else begin
         unique case (idx)
            4'd4:    b = 8'h04;
            4'd10:   b = 8'h08;
            4'd14:   b = 8'h0C;
            default: b = 8'h00;
         endcase
      end
      return b;
   endfunction

endpackage

// File: rtl/rsa_flag_reg.sv
module rsa_flag_reg #(
   parameter int unsigned CW     = 8,
   parameter int unsigned BIT    = 0,
   parameter logic        SEL    = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic          sel,
   input  logic [CW-1:0] wdata,
   output logic          q
);

   generate
      if (BIT >= CW) begin : g_bad_bit
         $error("rsa_flag_reg: BIT must be below CW");
      end
   endgenerate

   logic hit;
   assign hit = we && (sel == SEL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= 1'b0;
      end else if (hit) begin
         q <= wdata[BIT];
      end
   end

endmodule

// File: rtl/rsa_vec_pattern.sv
module rsa_vec_pattern
   import rom_share_pkg::*;
#(
   parameter int unsigned DW = 8
) (
   input  logic [PAT_IDX_W-1:0] idx,
   output logic [DW-1:0]        data
);

   generate
      if (DW < 8) begin : g_bad_dw
         $error("rsa_vec_pattern: DW must be at least 8");
      end
   endgenerate

   logic [DW-1:0] table_q [PAT_DEPTH];

   for (genvar i = 0; i < PAT_DEPTH; i++) begin : g_entry
      if (DW > 8) begin : g_wide
         assign table_q[i] = {{(DW-8){1'b0}}, sub_byte(PAT_IDX_W'(i))};
      end else begin : g_byte
         assign table_q[i] = sub_byte(PAT_IDX_W'(i));
      end
   end

   assign data = table_q[idx];

endmodule

// File: rtl/rsa_cop_gate.sv
module rsa_cop_gate (
   input  logic run_flag,
   input  logic own_flag,
   input  logic cop_req,
   output logic cop_owns,
   output logic cop_gnt
);

   assign cop_owns = run_flag && own_flag;
   assign cop_gnt  = cop_req && cop_owns;

endmodule

// File: rtl/rom_share_arb.sv
module rom_share_arb
   import rom_share_pkg::*;
#(
   parameter int unsigned AW      = 16,
   parameter int unsigned DW      = 8,
   parameter int unsigned CW      = 8,
   parameter int unsigned RUN_BIT = 5,
   parameter int unsigned OWN_BIT = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_we,
   input  logic          cfg_sel,
   input  logic [CW-1:0] cfg_wdata,
   input  logic          host_rd,
   input  logic [AW-1:0] host_addr,
   output logic [DW-1:0] host_rdata,
   input  logic          cop_req,
   input  logic [AW-1:0] cop_addr,
   output logic          cop_gnt,
   output logic [DW-1:0] cop_rdata,
   output logic          rom_rd,
   output logic [AW-1:0] rom_addr,
   input  logic [DW-1:0] rom_rdata
);

   generate
      if (AW < PAT_IDX_W) begin : g_bad_aw
         $error("rom_share_arb: AW too small for the pattern index");
      end
      if (RUN_BIT >= CW || OWN_BIT >= CW) begin : g_bad_bits
         $error("rom_share_arb: flag bit outside the control byte");
      end
   endgenerate

   localparam int unsigned RUN_IDX = int'(FLG_RUN);
   localparam int unsigned OWN_IDX = int'(FLG_OWN);
   localparam int unsigned FBIT [NUM_FLAGS] = '{RUN_BIT, OWN_BIT};

   logic [NUM_FLAGS-1:0] flags;
   logic                 cop_owns;
   logic [DW-1:0]        pat_data;

   for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_flag
      rsa_flag_reg #(
         .CW  (CW),
         .BIT (FBIT[f]),
         .SEL (1'(f))
      ) u_flag (
         .clk   (clk),
         .rst_n (rst_n),
         .we    (cfg_we),
         .sel   (cfg_sel),
         .wdata (cfg_wdata),
         .q     (flags[f])
      );
   end

   rsa_cop_gate u_gate (
      .run_flag (flags[RUN_IDX]),
      .own_flag (flags[OWN_IDX]),
      .cop_req  (cop_req),
      .cop_owns (cop_owns),
      .cop_gnt  (cop_gnt)
   );

   rsa_vec_pattern #(.DW(DW)) u_pat (
      .idx  (host_addr[PAT_IDX_W-1:0]),
      .data (pat_data)
   );

   // Memory side: the owner's address; the strobe comes from the owner only.
   assign rom_addr   = cop_owns ? cop_addr : host_addr;
   assign rom_rd     = (host_rd && !cop_owns) || cop_gnt;

   assign host_rdata = cop_owns ? pat_data : rom_rdata;
   assign cop_rdata  = rom_rdata;

endmodule

// File: rtl/rom_share_arb_chk.sv
module rom_share_arb_chk #(
   parameter int unsigned AW = 16,
   parameter int unsigned DW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cfg_we,
   input logic          host_rd,
   input logic [AW-1:0] host_addr,
   input logic [DW-1:0] host_rdata,
   input logic          cop_req,
   input logic [AW-1:0] cop_addr,
   input logic          cop_gnt,
   input logic          rom_rd,
   input logic [AW-1:0] rom_addr,
   input logic [DW-1:0] rom_rdata,
   input logic          cop_owns
);

   // R6
   gnt_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cop_gnt |-> cop_req);

   // R6
   gnt_drives_rom_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cop_gnt |-> (rom_rd && rom_addr == cop_addr));

   // R5
   sub_no_host_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cop_owns && !cop_req) |-> !rom_rd);

   // R3
   sub_low_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cop_gnt |-> (host_rdata[0] == host_addr[0]));

   // R2
   host_forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && rom_rd && !cop_req) |-> (host_rdata == rom_rdata));

   // R7
   own_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(cfg_we) |-> $stable(cop_owns));

endmodule

bind rom_share_arb rom_share_arb_chk #(.AW(AW), .DW(DW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_we     (cfg_we),
   .host_rd    (host_rd),
   .host_addr  (host_addr),
   .host_rdata (host_rdata),
   .cop_req    (cop_req),
   .cop_addr   (cop_addr),
   .cop_gnt    (cop_gnt),
   .rom_rd     (rom_rd),
   .rom_addr   (rom_addr),
   .rom_rdata  (rom_rdata),
   .cop_owns   (cop_owns)
);

// File: tb/sim_rom_share_arb.sv
`timescale 1ns/1ps
module sim_rom_share_arb;

   localparam int AW = 16;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic          cfg_sel = 1'b0;
   logic [7:0]    cfg_wdata = '0;
   logic          host_rd = 1'b0;
   logic [AW-1:0] host_addr = '0;
   logic [DW-1:0] host_rdata;
   logic          cop_req = 1'b0;
   logic [AW-1:0] cop_addr = '0;
   logic          cop_gnt;
   logic [DW-1:0] cop_rdata;
   logic          rom_rd;
   logic [AW-1:0] rom_addr;
   logic [DW-1:0] rom_rdata = '0;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   rom_share_arb u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .host_rd(host_rd), .host_addr(host_addr),
      .host_rdata(host_rdata), .cop_req(cop_req), .cop_addr(cop_addr),
      .cop_gnt(cop_gnt), .cop_rdata(cop_rdata), .rom_rd(rom_rd),
      .rom_addr(rom_addr), .rom_rdata(rom_rdata)
   );

   localparam logic [7:0] PAT [16] = '{
      8'h00, 8'h01, 8'h00, 8'h01, 8'h04, 8'h01, 8'h00, 8'h01,
      8'h00, 8'h01, 8'h08, 8'h01, 8'h00, 8'h01, 8'h0C, 8'h01};

   // run, own, host_addr, rom_rdata, cop_req
   typedef struct packed {
      logic        run;
      logic        own;
      logic [15:0] addr;
      logic [7:0]  rom;
      logic        req;
   } vec_t;

   localparam int NV = 8;
   localparam vec_t VEC [NV] = '{
      '{1'b0, 1'b0, 16'h1234, 8'hA5, 1'b0},
      '{1'b0, 1'b0, 16'hFFE4, 8'h5A, 1'b1},
      '{1'b1, 1'b0, 16'h00EA, 8'h3C, 1'b0},
      '{1'b1, 1'b0, 16'h8001, 8'hC3, 1'b1},
      '{1'b0, 1'b1, 16'h7FFE, 8'h99, 1'b0},
      '{1'b0, 1'b1, 16'h4444, 8'h66, 1'b1},
      '{1'b1, 1'b1, 16'hFFEA, 8'h77, 1'b0},
      '{1'b1, 1'b1, 16'h0004, 8'h88, 1'b1}};

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic sel, input logic [7:0] d, input logic we);
      @(negedge clk);
      cfg_sel = sel; cfg_wdata = d; cfg_we = we;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic set_flags(input logic run, input logic own);
      wr(1'b0, {2'b00, run, 5'b0}, 1'b1);
      wr(1'b1, {3'b000, own, 4'b0}, 1'b1);
   endtask

   initial begin : watchdog
      #400000;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
      $finish;
   end

   initial begin : main
      // R1 reset state
      host_rd = 1'b1; host_addr = 16'hFFEA; rom_rdata = 8'h42; cop_req = 1'b1;
      cop_addr = 16'h2222;
      #1;
      chk("R1 host_rdata", 32'(host_rdata), 32'h42);
      chk("R1 cop_gnt", 32'(cop_gnt), 0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      chk("R1 rom_rd", 32'(rom_rd), 1);
      chk("R1 rom_addr", 32'(rom_addr), 32'hFFEA);
      chk("R1 cop_gnt after reset", 32'(cop_gnt), 0);

      // R2 R5 R6 table walk
      for (int v = 0; v < NV; v++) begin
         logic sub;
         set_flags(VEC[v].run, VEC[v].own);
         host_addr = VEC[v].addr; rom_rdata = VEC[v].rom;
         cop_req = VEC[v].req; cop_addr = 16'h5000 + 16'(v);
         host_rd = 1'b1;
         #1;
         sub = VEC[v].run && VEC[v].own;
         chk("R2 host_rdata", 32'(host_rdata),
             sub ? 32'(PAT[VEC[v].addr[3:0]]) : 32'(VEC[v].rom));
         chk("R6 cop_gnt", 32'(cop_gnt), 32'(sub && VEC[v].req));
         chk("R5 rom_rd", 32'(rom_rd), sub ? 32'(VEC[v].req) : 1);
         chk("R5 rom_addr", 32'(rom_addr),
             sub ? 32'(16'h5000 + 16'(v)) : 32'(VEC[v].addr));
         chk("R6 cop_rdata", 32'(cop_rdata), 32'(VEC[v].rom));
      end

      // R3 all offsets, R4 upper bits ignored
      set_flags(1'b1, 1'b1);
      cop_req = 1'b0; rom_rdata = 8'hEE;
      for (int i = 0; i < 16; i++) begin
         @(negedge clk);
         host_addr = 16'(i); #1;
         chk("R3 pattern", 32'(host_rdata), 32'(PAT[i]));
         host_addr = 16'hABC0 | 16'(i); #1;
         chk("R4 upper bits", 32'(host_rdata), 32'(PAT[i]));
         chk("R5 no strobe", 32'(rom_rd), 0);
      end

      // R7 strobe low: no change
      wr(1'b0, 8'h00, 1'b0);
      host_addr = 16'h000A; #1;
      chk("R7 we low ignored", 32'(host_rdata), 32'h08);
      // R8 other data bits and other register ignored
      wr(1'b0, 8'hDF, 1'b1);       // bit5 = 0 clears run
      #1;
      chk("R8 run cleared", 32'(host_rdata), 32'hEE);
      wr(1'b1, 8'hEF, 1'b1);       // bit4 = 0 clears own, run still 0
      wr(1'b0, 8'h20, 1'b1);       // run = 1, own still 0
      #1;
      chk("R8 own kept cleared", 32'(host_rdata), 32'hEE);
      wr(1'b1, 8'h10, 1'b1);       // own = 1
      #1;
      chk("R8 both set", 32'(host_rdata), 32'h08);

      // R7 timing: update visible after the accepting edge
      @(negedge clk);
      cfg_sel = 1'b1; cfg_wdata = 8'h00; cfg_we = 1'b1; #1;
      chk("R7 before edge", 32'(host_rdata), 32'h08);
      @(posedge clk); #1;
      chk("R7 after edge", 32'(host_rdata), 32'hEE);
      cfg_we = 1'b0;

      // R6 stall held while host owns
      cop_req = 1'b1;
      repeat (3) begin
         @(negedge clk); #1;
         chk("R6 stall", 32'(cop_gnt), 0);
      end
      wr(1'b1, 8'h10, 1'b1); #1;
      chk("R6 grant on handback", 32'(cop_gnt), 1);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule